// File: doc/BRIEF.md
# Addressed Serial Multi-Channel Code Loader

This block is the digital front end of a six-channel level setter. A host drives three wires: a serial data line, a serial clock and a load strobe. Each 12-bit frame carries a 4-bit channel-select code and an 8-bit value. The block shifts the frame into a register on rising serial-clock edges. When the load strobe rises, the value is written into the holding register of the addressed channel. Every other channel keeps its value.

Each channel's 8-bit code is brought out raw. A downstream converter maps code N to a level of (N+1)/256 of the span above its low reference, so code 255 gives the full upper reference. A serial output presents the bit that leaves the top of the shift register. This lets several devices share one data path in a chain.

All three serial inputs pass through two-flop synchronizers into the system clock domain. Serial-clock edges and load-strobe edges are then found by edge detectors.

Top module: `serial_chan_loader`

## Requirements
- R1: On each synchronized rising edge of `sclk_i`, the frame register shifts left by one and takes `sdi_i` into bit 0. The wire order is the 4 select bits MSB first, then the 8 value bits MSB first. After 12 clocks the select code is in frame bits [11:8] and the value is in bits [7:0].
- R2: A rising edge of `ld_i` with select code S in 1..6 writes the value into channel S. Channel S is `chan_code_o[(S-1)*8 +: 8]`. The new value is visible no later than 3 system-clock edges after the edge that samples `ld_i` high. A strobe held high loads only once.
- R3: A load leaves the five channels that are not addressed unchanged.
- R4: Select code 0 and codes 7 through 15 update no channel.
- R5: While the synchronized `ld_i` is high, rising edges of `sclk_i` do not shift the frame register.
- R6: `sdo_o` changes only on a synchronized falling edge of `sclk_i`. At that edge it takes the value of frame bit 11. A frame shifted in therefore appears on `sdo_o` MSB first during the following 12 serial clocks.
- R7: Asynchronous reset (`rst_ni` low) clears all six channel codes, the frame register and `sdo_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdi_i | input | 1 | Serial data in, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, shifts on rising edge |
| ld_i | input | 1 | Load strobe, asynchronous, acts on rising edge |
| sdo_o | output | 1 | Cascade serial data out |
| chan_code_o | output | 48 | Six 8-bit channel codes; channel k is at bits [(k-1)*8 +: 8] |

## Verification
Each serial input pin reaches a result after two synchronizer flops and one edge-detect flop. A shift, a load or an `sdo_o` update therefore takes effect on the third system-clock edge after the pin changes. The bench holds every serial phase for four system cycles and samples four cycles after the last pin change, which keeps one cycle of margin. It samples `sdo_o` just before each serial rising edge, which is the moment a chained device would capture it. The load strobe is held high and low for six cycles each, so channel codes are read only after the write has settled.

// File: rtl/serial_chan_loader_pkg.sv
package serial_chan_loader_pkg;
  localparam int unsigned NUM_CH_D  = 6;
  localparam int unsigned VAL_W_D   = 8;
  localparam int unsigned SEL_W_D   = 4;
  localparam int unsigned SYNC_W    = 3;
  // bit positions in the synchronized input bus
  localparam int unsigned IDX_SDI   = 0;
  localparam int unsigned IDX_SCLK  = 1;
  localparam int unsigned IDX_LD    = 2;
endpackage

// File: rtl/scl_sync2.sv
module scl_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/scl_edge_det.sv
module scl_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/scl_frame_shifter.sv
module scl_frame_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               din_i,
  input  logic               out_upd_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] frame_q;
  logic               sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_q <= '0;
    else if (shift_i) frame_q <= {frame_q[FRAME_W-2:0], din_i};
  end

  // cascade bit moves on the serial falling edge, stable for next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sdo_q <= 1'b0;
    else if (out_upd_i) sdo_q <= frame_q[FRAME_W-1];
  end

  assign frame_o = frame_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/scl_latch_bank.sv
module scl_latch_bank #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned FRAME_W = VAL_W + SEL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [FRAME_W-1:0]      frame_i,
  output logic [NUM_CH*VAL_W-1:0] codes_o
);
  logic [SEL_W-1:0] sel;
  logic [VAL_W-1:0] val;

  assign sel = frame_i[FRAME_W-1 -: SEL_W];
  assign val = frame_i[VAL_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(ch + 1);
    logic             hit;
    logic [VAL_W-1:0] code_q;

    assign hit = load_i && (sel == MY_SEL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  code_q <= '0;
      else if (hit) code_q <= val;
    end

    assign codes_o[ch*VAL_W +: VAL_W] = code_q;
  end
endmodule

// File: rtl/serial_chan_loader.sv
module serial_chan_loader
  import serial_chan_loader_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_D,
  parameter int unsigned VAL_W  = VAL_W_D,
  parameter int unsigned SEL_W  = SEL_W_D,
  localparam int unsigned FRAME_W = VAL_W + SEL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sdi_i,
  input  logic                    sclk_i,
  input  logic                    ld_i,
  output logic                    sdo_o,
  output logic [NUM_CH*VAL_W-1:0] chan_code_o
);
  logic [SYNC_W-1:0]  pins_async, pins_sync;
  logic               sdi_lvl, sclk_lvl, ld_lvl;
  logic               sclk_rise, sclk_fall, ld_rise, ld_fall;
  logic               shift_en;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    pins_async           = '0;
    pins_async[IDX_SDI]  = sdi_i;
    pins_async[IDX_SCLK] = sclk_i;
    pins_async[IDX_LD]   = ld_i;
  end

  scl_sync2 #(.WIDTH(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_async),
    .sync_o (pins_sync)
  );

  assign sdi_lvl  = pins_sync[IDX_SDI];
  assign sclk_lvl = pins_sync[IDX_SCLK];
  assign ld_lvl   = pins_sync[IDX_LD];

  scl_edge_det u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_lvl),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  scl_edge_det u_ld_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ld_lvl),
    .rise_o(ld_rise),
    .fall_o(ld_fall)
  );

  assign shift_en = sclk_rise & ~ld_lvl;

  scl_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift_en),
    .din_i    (sdi_lvl),
    .out_upd_i(sclk_fall),
    .frame_o  (frame),
    .sdo_o    (sdo_o)
  );

  scl_latch_bank #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .SEL_W(SEL_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld_rise),
    .frame_i(frame),
    .codes_o(chan_code_o)
  );

  logic unused_fall;
  assign unused_fall = ld_fall;
endmodule

// File: rtl/serial_chan_loader_chk.sv
module serial_chan_loader_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned FRAME_W = VAL_W + SEL_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sdi_lvl,
  input logic                    sclk_rise,
  input logic                    sclk_fall,
  input logic                    ld_lvl,
  input logic                    ld_rise,
  input logic [FRAME_W-1:0]      frame,
  input logic                    sdo_o,
  input logic [NUM_CH*VAL_W-1:0] chan_code_o
);
  logic [SEL_W-1:0] sel;
  assign sel = frame[FRAME_W-1 -: SEL_W];

  assert_shift_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !ld_lvl) |=> (frame == {$past(frame[FRAME_W-2:0]), $past(sdi_lvl)}));

  assert_hold_while_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lvl |=> $stable(frame));

  assert_sdo_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdo_o));

  assert_sdo_tap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall |=> (sdo_o == $past(frame[FRAME_W-1])));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(ch + 1);

    assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_rise && sel == MY_SEL) |=>
        (chan_code_o[ch*VAL_W +: VAL_W] == $past(frame[VAL_W-1:0])));

    assert_other_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_rise && sel != MY_SEL) |=> $stable(chan_code_o[ch*VAL_W +: VAL_W]));

    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_rise |=> $stable(chan_code_o[ch*VAL_W +: VAL_W]));
  end

  assert_bad_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rise && (sel == '0 || sel > SEL_W'(NUM_CH))) |=> $stable(chan_code_o));
endmodule

bind serial_chan_loader serial_chan_loader_chk #(
  .NUM_CH(NUM_CH), .VAL_W(VAL_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sdi_lvl    (sdi_lvl),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall),
  .ld_lvl     (ld_lvl),
  .ld_rise    (ld_rise),
  .frame      (frame),
  .sdo_o      (sdo_o),
  .chan_code_o(chan_code_o)
);

// File: tb/serial_chan_loader_tb.sv
module serial_chan_loader_tb;
  localparam int NCH = 6;
  localparam int PH  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sdi_i = 1'b0, sclk_i = 1'b0, ld_i = 1'b0;
  logic sdo_o;
  logic [NCH*8-1:0] chan_code_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  model [NCH];
  logic [11:0] prev_frame = '0;

  always #5 clk_i = ~clk_i;

  serial_chan_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdi_i(sdi_i), .sclk_i(sclk_i),
    .ld_i(ld_i), .sdo_o(sdo_o), .chan_code_o(chan_code_o)
  );

  // {select, value}
  localparam logic [11:0] VEC [12] = '{
    {4'd1, 8'h5A}, {4'd2, 8'hA5}, {4'd3, 8'hFF}, {4'd4, 8'h01},
    {4'd5, 8'h80}, {4'd6, 8'h7E}, {4'd0, 8'hC3}, {4'd7, 8'h99},
    {4'd15, 8'h11}, {4'd6, 8'h00}, {4'd1, 8'hFF}, {4'd9, 8'h42}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serial_bit(input logic b, output logic seen);
    sdi_i = b;
    wait_cyc(PH);
    seen = sdo_o;
    sclk_i = 1'b1;
    wait_cyc(PH);
    sclk_i = 1'b0;
    wait_cyc(PH);
  endtask

  // shifts a frame; sdo must replay the previous frame MSB first (R6)
  task automatic send_frame(input logic [11:0] f);
    logic [11:0] got;
    logic s;
    for (int i = 11; i >= 0; i--) begin
      serial_bit(f[i], s);
      got[i] = s;
    end
    check("R6 cascade", {20'd0, got}, {20'd0, prev_frame});
    prev_frame = f;
  endtask

  task automatic pulse_ld();
    ld_i = 1'b1;
    wait_cyc(6);
    ld_i = 1'b0;
    wait_cyc(6);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++)
      check(req, {24'd0, chan_code_o[c*8 +: 8]}, {24'd0, model[c]});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = 8'h00;
    wait_cyc(5);
    check("R7 reset codes", {16'd0, chan_code_o}, 32'd0);
    check("R7 reset sdo", {31'd0, sdo_o}, 32'd0);
    rst_ni = 1'b1;
    wait_cyc(3);

    // R1 R2 R3 R4: table walk
    for (int v = 0; v < 12; v++) begin
      send_frame(VEC[v]);
      pulse_ld();
      if (VEC[v][11:8] >= 4'd1 && VEC[v][11:8] <= 4'd6)
        model[VEC[v][11:8] - 4'd1] = VEC[v][7:0];
      check_all("R1 R2 R3 R4 table");
    end

    // R5: shifting ignored while load strobe high
    begin
      logic s;
      send_frame({4'd2, 8'h3C});
      ld_i = 1'b1;
      wait_cyc(6);
      model[1] = 8'h3C;
      for (int k = 0; k < 3; k++) serial_bit(1'b1, s);
      ld_i = 1'b0;
      wait_cyc(6);
      pulse_ld();
      check_all("R5 no shift during load");
      send_frame({4'd3, 8'hC9});
      pulse_ld();
      model[2] = 8'hC9;
      check_all("R5 R2 after hold");
    end

    // R4: code 0 with a busy value leaves everything untouched
    send_frame({4'd0, 8'hEE});
    pulse_ld();
    check_all("R4 code zero");

    // R7: reset mid-run
    rst_ni = 1'b0;
    wait_cyc(2);
    check("R7 mid reset codes", {16'd0, chan_code_o}, 32'd0);
    check("R7 mid reset sdo", {31'd0, sdo_o}, 32'd0);
    rst_ni = 1'b1;
    wait_cyc(3);
    for (int c = 0; c < NCH; c++) model[c] = 8'h00;
    prev_frame = '0;
    send_frame({4'd4, 8'hB7});
    pulse_ld();
    model[3] = 8'hB7;
    check_all("R7 R2 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule